// File: doc/BRIEF.md
# Serial Boot Image Loader

This block fills on-chip program memory from an asynchronous serial line at power-up, then lets the host processor run from it. An 8-bit receiver with no parity turns the line into bytes. Each byte is written through a one-cycle write strobe to the next address of a memory region that begins at a base address parameter. After a fixed number of bytes the loader raises a completion flag, drops the processor hold, and stops storing. It does no integrity checking of any kind.

The receiver's oversampling tick comes from one of two sources. The first is an external clock pin running at sixteen times the bit rate. The second is an internal divider aimed at about 9600 baud. The divider has two settings, one for a fast reference clock (nominally 4.192 MHz) and one for a slow reference clock (nominally 32.768 kHz). The slow reference is too slow for sixteen-fold oversampling, so that setting uses a smaller oversampling ratio. A configuration pin picks the reference. The processor takes its start address from the boot address output, which always points at the first byte of the image.

Top module: `bil_loader`

## Requirements
- R1: The k-th received byte (k counted from 0) is written with `mem_we` high for one cycle, `mem_addr` = BASE_ADDR + k and `mem_wdata` equal to the byte.
- R2: Exactly IMAGE_BYTES bytes are written. Bytes received after that produce no write.
- R3: `load_done` first goes high in the same cycle as the last image write and stays high until reset. `cpu_hold` is high from reset until `load_done` rises, and low after that.
- R4: `cpu_boot_addr` equals BASE_ADDR at all times.
- R5: A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The stop bit level is not checked: a frame whose stop bit is low is still stored.
- R6: With `clk_src_ext` = 1, each rising edge of `ext_clk16` (after a two-flop synchronizer) is one oversampling tick, and a bit lasts 16 ticks.
- R7: With `clk_src_ext` = 0 and `ref_slow` = 0, a tick occurs every DIV_FAST system clocks, and a bit lasts 16 ticks.
- R8: With `clk_src_ext` = 0 and `ref_slow` = 1, a tick occurs every DIV_SLOW system clocks, and a bit lasts OSR_SLOW ticks.
- R9: A falling edge starts a frame only if the line is still low at the mid-bit sample, OSR/2 ticks later. A shorter low pulse writes nothing.
- R10: After synchronous reset, `mem_we` = 0, `load_done` = 0, `cpu_hold` = 1, and the next write goes to BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_src_ext | input | 1 | 1: tick from ext_clk16; 0: internal divider |
| ref_slow | input | 1 | Internal mode only. 1: slow reference divider; 0: fast reference divider |
| ext_clk16 | input | 1 | External clock at 16 times the bit rate |
| rxd | input | 1 | Serial data line, idles high |
| mem_we | output | 1 | One-cycle write strobe to program RAM |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data |
| load_done | output | 1 | Image fully stored |
| cpu_hold | output | 1 | Holds the processor while high |
| cpu_boot_addr | output | ADDR_W | Start address for the processor |

## Verification
The bench loads a full image in each of the three clock configurations and appends surplus bytes after the last one. A loader that miscounts would write a surplus byte or stop one byte short. It would also raise `load_done` one cycle away from the last strobe. Directed bytes 0x00, 0xFF, 0x01 and 0x80 lead each image, so a receiver that shifts in the wrong direction returns mirrored data. One frame carries a low stop bit; a receiver that checks framing drops that frame and shifts every later address. A short low glitch precedes one frame. A receiver without mid-bit confirmation would store a spurious byte at the base address.

// File: rtl/bil_pkg.sv
package bil_pkg;

    // Width of the oversampling tick counter; holds ratios up to 16.
    localparam int OSR_W   = 5;
    localparam int OSR_STD = 16;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    // Tick count from a detected falling edge to the start-bit check.
    function automatic logic [OSR_W-1:0] mid_point(input logic [OSR_W-1:0] osr);
        return osr >> 1;
    endfunction

endpackage

// File: rtl/bil_tick_gen.sv
module bil_tick_gen
    import bil_pkg::*;
#(
    parameter int DIV_FAST = 27,
    parameter int DIV_SLOW = 1,
    parameter int OSR_SLOW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_ext,
    input  logic             ref_slow,
    input  logic             ext_clk16,
    output logic             tick,
    output logic [OSR_W-1:0] osr
);
    localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int DW   = (DMAX > 2) ? $clog2(DMAX) : 1;

    logic [DW-1:0] dcnt;
    logic [DW-1:0] dlim;
    logic          div_tick;
    logic [2:0]    esh;
    logic          ext_tick;

    // Divider: one tick every DIV_x system clocks.
    assign dlim     = ref_slow ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
    assign div_tick = (dcnt >= dlim);

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
        end else if (div_tick) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + DW'(1);
        end
    end

    // Two synchronizer stages, then a third stage for rising-edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            esh <= '0;
        end else begin
            esh <= {esh[1:0], ext_clk16};
        end
    end

    assign ext_tick = esh[1] & ~esh[2];

    assign tick = use_ext ? ext_tick : div_tick;
    assign osr  = (!use_ext && ref_slow) ? OSR_W'(OSR_SLOW) : OSR_W'(OSR_STD);

endmodule

// File: rtl/bil_uart_rx.sv
module bil_uart_rx
    import bil_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic             tick,
    input  logic [OSR_W-1:0] osr,
    output rx_byte_t         rx_out
);
    rx_state_t        state;
    logic [1:0]       sync;
    logic             line_d;
    logic             line;
    logic [OSR_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic [OSR_W-1:0] last_tick;

    assign line      = sync[1];
    assign last_tick = osr - OSR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= 2'b11;
            line_d <= 1'b1;
            state  <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            rx_out <= '0;
        end else begin
            sync         <= {sync[0], rxd};
            line_d       <= line;
            rx_out.valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (line_d && !line) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt + OSR_W'(1) == mid_point(osr)) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + OSR_W'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == last_tick) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[7:1]};
                            if (bitn == 3'd7) begin
                                state <= RX_STOP;
                            end else begin
                                bitn <= bitn + 3'd1;
                            end
                        end else begin
                            cnt <= cnt + OSR_W'(1);
                        end
                    end
                end
                RX_STOP: begin
                    // Stop level is sampled by position only; no framing check.
                    if (tick) begin
                        if (cnt == last_tick) begin
                            cnt          <= '0;
                            state        <= RX_IDLE;
                            rx_out.valid <= 1'b1;
                            rx_out.data  <= shreg;
                        end else begin
                            cnt <= cnt + OSR_W'(1);
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bil_store.sv
module bil_store
    import bil_pkg::*;
#(
    parameter int          IMAGE_BYTES = 576,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_byte_t          rx_in,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata,
    output logic              done
);
    localparam int CNT_W = $clog2(IMAGE_BYTES + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            done  <= 1'b0;
            we    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            we <= 1'b0;
            if (rx_in.valid && !done) begin
                we    <= 1'b1;
                addr  <= ADDR_W'(BASE_ADDR) + ADDR_W'(count);
                wdata <= rx_in.data;
                count <= count + CNT_W'(1);
                if (count == CNT_W'(IMAGE_BYTES - 1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bil_loader.sv
module bil_loader
    import bil_pkg::*;
#(
    parameter int          IMAGE_BYTES = 576,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 32'h0000_0400,
    parameter int          DIV_FAST    = 27,
    parameter int          DIV_SLOW    = 1,
    parameter int          OSR_SLOW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_src_ext,
    input  logic              ref_slow,
    input  logic              ext_clk16,
    input  logic              rxd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              load_done,
    output logic              cpu_hold,
    output logic [ADDR_W-1:0] cpu_boot_addr
);
    logic             tick;
    logic [OSR_W-1:0] osr;
    rx_byte_t         rx_byte;

    bil_tick_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW),
        .OSR_SLOW (OSR_SLOW)
    ) u_tick (
        .clk       (clk),
        .rst       (rst),
        .use_ext   (clk_src_ext),
        .ref_slow  (ref_slow),
        .ext_clk16 (ext_clk16),
        .tick      (tick),
        .osr       (osr)
    );

    bil_uart_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .rxd    (rxd),
        .tick   (tick),
        .osr    (osr),
        .rx_out (rx_byte)
    );

    bil_store #(
        .IMAGE_BYTES (IMAGE_BYTES),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_byte),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .done  (load_done)
    );

    assign cpu_hold      = ~load_done;
    assign cpu_boot_addr = ADDR_W'(BASE_ADDR);

endmodule

// File: rtl/bil_loader_chk.sv
module bil_loader_chk #(
    parameter int          IMAGE_BYTES = 576,
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 32'h0000_0400
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              load_done,
    input logic              cpu_hold
);
    localparam int CNT_W = $clog2(IMAGE_BYTES + 1);

    logic [CNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (mem_we) begin
            wcnt <= wcnt + CNT_W'(1);
        end
    end

    p_addr_seq_r1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == ADDR_W'(BASE_ADDR) + ADDR_W'(wcnt));

    p_we_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_no_write_after_done_r2: assert property (@(posedge clk) disable iff (rst)
        $past(load_done) |-> !mem_we);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        wcnt <= CNT_W'(IMAGE_BYTES));

    p_done_with_last_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> mem_we && wcnt == CNT_W'(IMAGE_BYTES - 1));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);

    p_hold_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_hold) |-> $rose(load_done));

    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cpu_hold && !mem_we && !load_done);

endmodule

bind bil_loader bil_loader_chk #(
    .IMAGE_BYTES (IMAGE_BYTES),
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .load_done (load_done),
    .cpu_hold  (cpu_hold)
);

// File: tb/sim_bil_loader.sv
module sim_bil_loader;
    localparam int          NB     = 24;
    localparam int          EXTRA  = 3;
    localparam int          ADDR_W = 16;
    localparam int unsigned BASE   = 32'h0000_0400;
    localparam int          DIVF   = 2;
    localparam int          DIVS   = 4;
    localparam int          OSRS   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_src_ext = 1'b0;
    logic              ref_slow = 1'b0;
    logic              ext_clk16 = 1'b0;
    logic              rxd = 1'b1;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              load_done;
    logic              cpu_hold;
    logic [ADDR_W-1:0] cpu_boot_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;
    always #16 ext_clk16 = ~ext_clk16;

    bil_loader #(
        .IMAGE_BYTES (NB),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE),
        .DIV_FAST    (DIVF),
        .DIV_SLOW    (DIVS),
        .OSR_SLOW    (OSRS)
    ) u0 (
        .clk           (clk),
        .rst           (rst),
        .clk_src_ext   (clk_src_ext),
        .ref_slow      (ref_slow),
        .ext_clk16     (ext_clk16),
        .rxd           (rxd),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .load_done     (load_done),
        .cpu_hold      (cpu_hold),
        .cpu_boot_addr (cpu_boot_addr)
    );

    // Write monitor, sampled on the falling edge.
    logic [ADDR_W-1:0] got_addr [64];
    logic [7:0]        got_data [64];
    logic              got_done [64];
    int                wr_cnt;

    always @(negedge clk) begin
        if (rst) begin
            wr_cnt <= 0;
        end else if (mem_we) begin
            if (wr_cnt < 64) begin
                got_addr[wr_cnt] <= mem_addr;
                got_data[wr_cnt] <= mem_wdata;
                got_done[wr_cnt] <= load_done;
            end
            wr_cnt <= wr_cnt + 1;
        end
    end

    logic [7:0] exp_data [NB+EXTRA];

    function automatic logic [ADDR_W-1:0] exp_addr(input int k);
        return ADDR_W'(BASE + k);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rxd = 1'b1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_we, "R10", "we after reset", int'(mem_we), 0);
        chk(!load_done, "R10", "done after reset", int'(load_done), 0);
        chk(cpu_hold, "R10", "hold after reset", int'(cpu_hold), 1);
        chk(cpu_boot_addr == ADDR_W'(BASE), "R4", "boot address",
            int'(cpu_boot_addr), int'(BASE));
    endtask

    task automatic send_byte(input logic [7:0] b, input int bitc, input bit stop_lvl);
        rxd = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitc) @(negedge clk);
        end
        rxd = stop_lvl;
        repeat (bitc) @(negedge clk);
        rxd = 1'b1;
        if (!stop_lvl) repeat (bitc) @(negedge clk);
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic run_load(input bit ext, input bit slow, input int bitc,
                            input int bad_idx, input string rq);
        int mism;
        clk_src_ext = ext;
        ref_slow    = slow;
        do_reset();
        for (int i = 0; i < NB + EXTRA; i++) exp_data[i] = 8'($urandom);
        exp_data[0] = 8'h00;
        exp_data[1] = 8'hFF;
        exp_data[2] = 8'h01;
        exp_data[3] = 8'h80;
        for (int i = 0; i < NB + EXTRA; i++) begin
            send_byte(exp_data[i], bitc, (i == bad_idx) ? 1'b0 : 1'b1);
            if (i == NB - 2)
                chk(cpu_hold && !load_done, "R3", "hold before last byte",
                    int'(cpu_hold), 1);
        end
        repeat (4 * bitc) @(negedge clk);
        chk(wr_cnt == NB, "R2", "write count incl. surplus bytes", wr_cnt, NB);
        mism = 0;
        for (int i = 0; i < NB; i++) begin
            chk(got_addr[i] == exp_addr(i), "R1", "write address",
                int'(got_addr[i]), int'(exp_addr(i)));
            chk(got_data[i] == exp_data[i], "R1", "write data",
                int'(got_data[i]), int'(exp_data[i]));
            chk(got_done[i] == (i == NB - 1), "R3", "done alignment with write",
                int'(got_done[i]), int'(i == NB - 1));
            if (got_data[i] != exp_data[i]) mism++;
        end
        chk(mism == 0, rq, "bytes received in this clock mode", mism, 0);
        chk(got_data[0] == 8'h00 && got_data[1] == 8'hFF &&
            got_data[2] == 8'h01 && got_data[3] == 8'h80, "R5", "bit order",
            int'(got_data[2]), 1);
        if (bad_idx >= 0)
            chk(got_data[bad_idx] == exp_data[bad_idx], "R5", "low stop bit stored",
                int'(got_data[bad_idx]), int'(exp_data[bad_idx]));
        chk(load_done && !cpu_hold, "R3", "released after image",
            int'(cpu_hold), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0B17));
        // External 16x clock: ext period 4 clocks, bit 64 clocks.
        run_load(1'b1, 1'b0, 64, -1, "R6");
        // Internal fast reference: bit 16 * DIVF clocks.
        run_load(1'b0, 1'b0, 16 * DIVF, 7, "R7");
        // Internal slow reference: bit OSRS * DIVS clocks.
        run_load(1'b0, 1'b1, OSRS * DIVS, 11, "R8");

        // R9: a short low glitch must not start a frame.
        clk_src_ext = 1'b0;
        ref_slow    = 1'b0;
        do_reset();
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * 16 * DIVF) @(negedge clk);
        chk(wr_cnt == 0, "R9", "no write from glitch", wr_cnt, 0);
        send_byte(8'hA5, 16 * DIVF, 1'b1);
        repeat (2 * 16 * DIVF) @(negedge clk);
        chk(wr_cnt == 1, "R9", "single write after glitch", wr_cnt, 1);
        chk(got_data[0] == 8'hA5 && got_addr[0] == exp_addr(0), "R9",
            "first real byte at base", int'(got_data[0]), 'hA5);
        chk(cpu_hold && !load_done, "R3", "hold kept while loading",
            int'(cpu_hold), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule